// File: doc/BRIEF.md
# Card Data Path Sequencer

This block sequences the data phase of a memory-card host controller. Software writes an 8-bit control word and, in a separate register, the number of bytes to move. When the control word carries a start request while the sequencer is idle, the block enters a send state (host to card) or a receive state (card to host). It loads a byte down-counter from the length register, then moves one byte per completed ready/valid handshake on the card side. When the counter reaches zero it returns to idle and raises a sticky completion flag.

In block mode the transfer is divided into blocks of 2^n bytes, and a one-cycle pulse marks the end of each block. In stream mode no block pulses are emitted. An optional DMA request follows byte availability while a transfer is running. The card clock and the bus clock are modelled as single-cycle strobes in one clock domain. This lets the write lockout that follows every control write be counted exactly: three card-clock strobes and two bus-clock strobes.

Top module: `card_data_seq`

## Requirements
- R1: After synchronous reset the block is idle. `xfer_busy`, `data_end`, `wr_dropped`, `dma_req`, `blk_end` and `bytes_left` are all 0.
- R2: Control word layout: bit 0 start, bit 1 direction, bit 2 mode, bit 3 DMA enable, bits 7:4 block-size code. An accepted write with start=1 in idle makes the block busy on the next cycle. Direction 0 selects send, where `card_tx_valid` is high while bytes remain. Direction 1 selects receive, where `card_rx_ready` is high while bytes remain. When idle, neither handshake signal is asserted.
- R3: On the start, `bytes_left` is loaded with the current length register value, and that value is visible in the first busy cycle.
- R4: Each send handshake (`card_tx_valid`&`card_tx_ready`) or receive handshake (`card_rx_ready`&`card_rx_valid`) decrements `bytes_left` by one. The cycle after the last byte, the block is idle and `data_end` is 1.
- R5: A length of 0 offers no handshake. The block is idle with `data_end` set one cycle after its single busy cycle.
- R6: Mode 0 (block): `blk_end` pulses for one cycle after every 2^n-th byte of a block, where n is the block-size code. Codes 12 to 15 behave as code 11 (2048 bytes).
- R7: Mode 1 (stream): `blk_end` never pulses.
- R8: After an accepted control write, further control writes are dropped until three `mclk_stb` strobes and two `pclk_stb` strobes have been seen. A dropped write sets the sticky `wr_dropped` flag and starts nothing.
- R9: `dma_req` is high only when DMA is enabled, the block is busy with bytes remaining, and the card side can take a byte (send, `card_tx_ready`) or offers one (receive, `card_rx_valid`).
- R10: An accepted start write while busy changes neither direction nor count. `data_end` clears when a new transfer starts.
- R11: `card_tx_data` follows `host_tx_data`, and `host_rx_data` follows `card_rx_data`. `host_rx_stb` marks each receive handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_stb | input | 1 | Card-clock strobe |
| pclk_stb | input | 1 | Bus-clock strobe |
| ctrl_wr | input | 1 | Control word write |
| ctrl_wdata | input | 8 | Control word |
| len_wr | input | 1 | Length register write |
| len_wdata | input | LEN_W | Transfer length in bytes |
| host_tx_data | input | 8 | Byte from host for send |
| card_tx_valid | output | 1 | Send byte offered to card |
| card_tx_ready | input | 1 | Card accepts send byte |
| card_tx_data | output | 8 | Send byte to card |
| card_rx_valid | input | 1 | Card offers receive byte |
| card_rx_ready | output | 1 | Block accepts receive byte |
| card_rx_data | input | 8 | Receive byte from card |
| host_rx_data | output | 8 | Receive byte to host |
| host_rx_stb | output | 1 | Receive byte taken this cycle |
| dma_req | output | 1 | DMA service request |
| xfer_busy | output | 1 | Transfer in progress |
| bytes_left | output | LEN_W | Remaining byte count |
| blk_end | output | 1 | One-cycle block completion pulse |
| data_end | output | 1 | Sticky transfer completion flag |
| wr_dropped | output | 1 | Sticky dropped-write flag |

## Verification
The assertions assume the card-side handshake inputs are ordinary levels sampled every cycle. They also assume the strobes are single-cycle enables, with no relation required between the strobes and the writes. The stimulus drives every input on the falling edge and draws ready/valid levels at random at about 60 percent. It asserts the strobes only inside a dedicated lockout-release step, so every write lands either clearly inside or clearly after the lockout window. Lengths and block-size codes are drawn from small ranges, and one directed transfer uses a reserved code with a length just over 2048 bytes.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int BLK_CODE_MAX = 11;
    localparam int BLK_W        = BLK_CODE_MAX + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [3:0] bsize;
        logic       dma;
        logic       mode;
        logic       dir;
        logic       go;
    } ctrl_word_t;

    // Index of the last byte in a block; reserved codes saturate.
    function automatic logic [BLK_W-1:0] blk_last(input logic [3:0] code);
        logic [3:0]       eff;
        logic [BLK_W-1:0] one;
        one = BLK_W'(1);
        eff = (code > 4'(BLK_CODE_MAX)) ? 4'(BLK_CODE_MAX) : code;
        return (one << eff) - one;
    endfunction

endpackage

// File: rtl/cds_write_gate.sv
module cds_write_gate #(
    parameter int MCLK_LOCK = 3,
    parameter int PCLK_LOCK = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic mstb_i,
    input  logic pstb_i,
    output logic accept_o,
    output logic dropped_o
);
    localparam int MW = $clog2(MCLK_LOCK + 1);
    localparam int PW = $clog2(PCLK_LOCK + 1);

    logic          lock_q;
    logic [MW-1:0] mcnt_q, mcnt_n;
    logic [PW-1:0] pcnt_q, pcnt_n;

    assign accept_o = wr_i && !lock_q;

    always_comb begin
        mcnt_n = mcnt_q;
        pcnt_n = pcnt_q;
        if (mstb_i && (mcnt_q < MW'(MCLK_LOCK))) mcnt_n = mcnt_q + 1'b1;
        if (pstb_i && (pcnt_q < PW'(PCLK_LOCK))) pcnt_n = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            mcnt_q    <= '0;
            pcnt_q    <= '0;
            dropped_o <= 1'b0;
        end else if (accept_o) begin
            lock_q <= 1'b1;
            mcnt_q <= '0;
            pcnt_q <= '0;
        end else if (lock_q) begin
            mcnt_q <= mcnt_n;
            pcnt_q <= pcnt_n;
            lock_q <= !((mcnt_n == MW'(MCLK_LOCK)) && (pcnt_n == PW'(PCLK_LOCK)));
            if (wr_i) dropped_o <= 1'b1;
        end
    end

    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && lock_q) |=> dropped_o);
    assert_lock_arm_R8: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (lock_q && !accept_o));
endmodule

// File: rtl/cds_counters.sv
module cds_counters
    import cds_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             xfer_i,
    input  logic             blk_mode_i,
    input  logic [3:0]       bsize_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic             cnt_zero_o,
    output logic             cnt_one_o,
    output logic             blk_end_o
);
    logic [BLK_W-1:0] bcnt_q;
    logic [BLK_W-1:0] last_idx;

    assign last_idx   = blk_last(bsize_i);
    assign cnt_zero_o = (cnt_o == '0);
    assign cnt_one_o  = (cnt_o == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o     <= '0;
            bcnt_q    <= '0;
            blk_end_o <= 1'b0;
        end else begin
            blk_end_o <= 1'b0;
            if (load_i) begin
                cnt_o  <= len_i;
                bcnt_q <= '0;
            end else if (xfer_i) begin
                cnt_o <= cnt_o - 1'b1;
                if (blk_mode_i) begin
                    if (bcnt_q == last_idx) begin
                        bcnt_q    <= '0;
                        blk_end_o <= 1'b1;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !load_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
    assert_stream_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!blk_mode_i && !load_i) |=> !blk_end_o);
endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
    import cds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept_i,
    input  ctrl_word_t wr_i,
    input  logic       cnt_zero_i,
    input  logic       cnt_one_i,
    input  logic       xfer_i,
    output seq_state_t state_o,
    output logic       load_o,
    output logic       dir_o,
    output logic       blk_mode_o,
    output logic       dma_o,
    output logic [3:0] bsize_o,
    output logic       data_end_o
);
    seq_state_t state_n;
    logic       finish;

    assign load_o = accept_i && wr_i.go && (state_o == ST_IDLE);
    assign finish = (state_o != ST_IDLE) && (cnt_zero_i || (xfer_i && cnt_one_i));

    always_comb begin
        state_n = state_o;
        unique case (state_o)
            ST_IDLE: if (load_o) state_n = wr_i.dir ? ST_RECV : ST_SEND;
            ST_SEND,
            ST_RECV: if (finish) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o    <= ST_IDLE;
            dir_o      <= 1'b0;
            blk_mode_o <= 1'b0;
            dma_o      <= 1'b0;
            bsize_o    <= '0;
            data_end_o <= 1'b0;
        end else begin
            state_o <= state_n;
            if (load_o) begin
                dir_o      <= wr_i.dir;
                blk_mode_o <= !wr_i.mode;
                dma_o      <= wr_i.dma;
                bsize_o    <= wr_i.bsize;
                data_end_o <= 1'b0;
            end else if (finish) begin
                data_end_o <= 1'b1;
            end
        end
    end

    assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (state_o != ST_IDLE && !data_end_o));
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o != ST_IDLE && accept_i) |=> (dir_o == $past(dir_o)));
endmodule

// File: rtl/card_data_seq.sv
module card_data_seq
    import cds_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MCLK_LOCK = 3,
    parameter int PCLK_LOCK = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclk_stb,
    input  logic             pclk_stb,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic [7:0]       host_tx_data,
    output logic             card_tx_valid,
    input  logic             card_tx_ready,
    output logic [7:0]       card_tx_data,
    input  logic             card_rx_valid,
    output logic             card_rx_ready,
    input  logic [7:0]       card_rx_data,
    output logic [7:0]       host_rx_data,
    output logic             host_rx_stb,
    output logic             dma_req,
    output logic             xfer_busy,
    output logic [LEN_W-1:0] bytes_left,
    output logic             blk_end,
    output logic             data_end,
    output logic             wr_dropped
);
    ctrl_word_t       wr_word;
    seq_state_t       state;
    logic             accept, load, dir_q, blk_mode, dma_en;
    logic [3:0]       bsize;
    logic             cnt_zero, cnt_one, xfer;
    logic [LEN_W-1:0] len_q;

    assign wr_word = ctrl_word_t'(ctrl_wdata);

    always_ff @(posedge clk) begin
        if (rst)         len_q <= '0;
        else if (len_wr) len_q <= len_wdata;
    end

    cds_write_gate #(.MCLK_LOCK(MCLK_LOCK), .PCLK_LOCK(PCLK_LOCK)) u_gate (
        .clk(clk), .rst(rst), .wr_i(ctrl_wr), .mstb_i(mclk_stb), .pstb_i(pclk_stb),
        .accept_o(accept), .dropped_o(wr_dropped)
    );

    cds_fsm u_fsm (
        .clk(clk), .rst(rst), .accept_i(accept), .wr_i(wr_word),
        .cnt_zero_i(cnt_zero), .cnt_one_i(cnt_one), .xfer_i(xfer),
        .state_o(state), .load_o(load), .dir_o(dir_q), .blk_mode_o(blk_mode),
        .dma_o(dma_en), .bsize_o(bsize), .data_end_o(data_end)
    );

    cds_counters #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst(rst), .load_i(load), .len_i(len_q), .xfer_i(xfer),
        .blk_mode_i(blk_mode), .bsize_i(bsize), .cnt_o(bytes_left),
        .cnt_zero_o(cnt_zero), .cnt_one_o(cnt_one), .blk_end_o(blk_end)
    );

    assign xfer_busy     = (state != ST_IDLE);
    assign card_tx_valid = (state == ST_SEND) && !cnt_zero;
    assign card_rx_ready = (state == ST_RECV) && !cnt_zero;
    assign xfer          = (card_tx_valid && card_tx_ready) || (card_rx_ready && card_rx_valid);
    assign card_tx_data  = host_tx_data;
    assign host_rx_data  = card_rx_data;
    assign host_rx_stb   = card_rx_ready && card_rx_valid;
    assign dma_req       = dma_en && ((card_tx_valid && card_tx_ready) ||
                                      (card_rx_ready && card_rx_valid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !(card_tx_valid || card_rx_ready || host_rx_stb));
    assert_last_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_busy && bytes_left == LEN_W'(1) && xfer) |=> (!xfer_busy && data_end));
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_busy && bytes_left == '0) |=> (!xfer_busy && data_end));
    assert_dma_gated_R9: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (xfer_busy && bytes_left != '0));
endmodule

// File: tb/sim_card_data_seq.sv
`timescale 1ns/1ps
module sim_card_data_seq;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk_stb = 0, pclk_stb = 0, ctrl_wr = 0, len_wr = 0;
    logic [7:0] ctrl_wdata = '0, host_tx_data = '0, card_rx_data = '0;
    logic [LEN_W-1:0] len_wdata = '0;
    logic card_tx_ready = 0, card_rx_valid = 0;
    logic card_tx_valid, card_rx_ready, host_rx_stb, dma_req, xfer_busy;
    logic blk_end, data_end, wr_dropped;
    logic [7:0] card_tx_data, host_rx_data;
    logic [LEN_W-1:0] bytes_left;

    int nchk = 0, nfail = 0;
    // bench model of the requirements
    bit m_busy, m_dir, m_mode, m_dma, m_blkp, m_end;
    int m_bsz, m_cnt, m_bc, m_len;

    always #2 clk = ~clk;

    card_data_seq #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .mclk_stb(mclk_stb), .pclk_stb(pclk_stb),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .len_wr(len_wr), .len_wdata(len_wdata),
        .host_tx_data(host_tx_data), .card_tx_valid(card_tx_valid),
        .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data),
        .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
        .card_rx_data(card_rx_data), .host_rx_data(host_rx_data), .host_rx_stb(host_rx_stb),
        .dma_req(dma_req), .xfer_busy(xfer_busy), .bytes_left(bytes_left),
        .blk_end(blk_end), .data_end(data_end), .wr_dropped(wr_dropped)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int blen(input int code);
        return 1 << ((code > 11) ? 11 : code);
    endfunction

    task automatic set_len(input int l);
        @(negedge clk); len_wr = 1; len_wdata = LEN_W'(l);
        @(negedge clk); len_wr = 0;
        m_len = l;
    endtask

    task automatic clear_lock();
        @(negedge clk); mclk_stb = 1; pclk_stb = 1;
        repeat (3) @(negedge clk);
        mclk_stb = 0; pclk_stb = 0;
    endtask

    task automatic start(input bit dir, input bit mode, input bit dma, input int bsz);
        @(negedge clk);
        ctrl_wr = 1;
        ctrl_wdata = {4'(bsz), dma, mode, dir, 1'b1};
        m_busy = 1; m_dir = dir; m_mode = mode; m_dma = dma; m_bsz = bsz;
        m_cnt = m_len; m_bc = 0; m_blkp = 0; m_end = 0;
    endtask

    task automatic run();
        bit r, hs;
        string t;
        while (1) begin
            @(negedge clk);
            ctrl_wr = 0;
            r = ($urandom % 100) < 60;
            card_tx_ready = r; card_rx_valid = r;
            host_tx_data = 8'($urandom); card_rx_data = 8'($urandom);
            #1;
            hs = m_busy && (m_cnt != 0) && r;
            chk(xfer_busy == m_busy, "R2 busy", xfer_busy, m_busy);
            chk(card_tx_valid == (m_busy && !m_dir && m_cnt != 0), "R2 tx_valid", card_tx_valid, 0);
            chk(card_rx_ready == (m_busy && m_dir && m_cnt != 0), "R2 rx_ready", card_rx_ready, 0);
            if (m_busy) begin
                t = (m_len == 0) ? "R5 bytes_left" : "R3 R4 bytes_left";
                chk(bytes_left == LEN_W'(m_cnt), t, bytes_left, m_cnt);
            end
            t = m_mode ? "R7 blk_end" : "R6 blk_end";
            chk(blk_end == m_blkp, t, blk_end, m_blkp);
            t = (m_len == 0) ? "R5 data_end" : "R4 R10 data_end";
            chk(data_end == m_end, t, data_end, m_end);
            chk(dma_req == (m_dma && hs), "R9 dma_req", dma_req, m_dma && hs);
            chk(card_tx_data == host_tx_data, "R11 tx data", card_tx_data, host_tx_data);
            chk(host_rx_data == card_rx_data, "R11 rx data", host_rx_data, card_rx_data);
            chk(host_rx_stb == (hs && m_dir), "R11 rx strobe", host_rx_stb, hs && m_dir);
            if (!m_busy) break;
            m_blkp = 0;
            if (m_cnt == 0) begin
                m_busy = 0; m_end = 1;
            end else if (hs) begin
                m_cnt--;
                if (!m_mode) begin
                    if (m_bc == blen(m_bsz) - 1) begin m_blkp = 1; m_bc = 0; end
                    else m_bc++;
                end
                if (m_cnt == 0) begin m_busy = 0; m_end = 1; end
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk(!xfer_busy && !data_end && !dma_req && !blk_end, "R1 flags", xfer_busy, 0);
        chk(wr_dropped == 0, "R1 wr_dropped", wr_dropped, 0);
        chk(bytes_left == 0, "R1 bytes_left", bytes_left, 0);

        // R8: lockout holds with 3 card strobes but only 1 bus strobe
        set_len(3);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = 8'h00;
        @(negedge clk); ctrl_wr = 0; mclk_stb = 1; pclk_stb = 1;
        @(negedge clk); pclk_stb = 0;
        repeat (2) @(negedge clk);
        mclk_stb = 0; ctrl_wr = 1; ctrl_wdata = 8'h11;
        @(negedge clk); ctrl_wr = 0; #1;
        chk(wr_dropped == 1, "R8 dropped flag", wr_dropped, 1);
        chk(xfer_busy == 0, "R8 dropped start", xfer_busy, 0);
        @(negedge clk); pclk_stb = 1;
        @(negedge clk); pclk_stb = 0;
        start(0, 0, 0, 1);   // accepted now: send, block, 2-byte blocks
        run();

        // R10: start write during a busy transfer is ignored
        set_len(6);
        clear_lock();
        start(0, 1, 0, 0);
        @(negedge clk); ctrl_wr = 0; card_tx_ready = 0; card_rx_valid = 0;
        clear_lock();
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = 8'h03;
        @(negedge clk); ctrl_wr = 0; #1;
        chk(card_tx_valid == 1 && card_rx_ready == 0, "R10 direction kept", card_rx_ready, 0);
        chk(bytes_left == 6, "R10 count kept", bytes_left, 6);
        run();

        // R5: zero length
        set_len(0); clear_lock(); start(0, 0, 1, 0); run();
        // R9 / R7: receive stream with DMA
        set_len(9); clear_lock(); start(1, 1, 1, 2); run();
        // R6: block size 1 byte, receive
        set_len(5); clear_lock(); start(1, 0, 1, 0); run();
        // R6: reserved code 13 behaves as 2048-byte blocks
        set_len(2050); clear_lock(); start(1, 0, 0, 13); run();

        for (int i = 0; i < 24; i++) begin
            set_len($urandom % 20);
            clear_lock();
            start(1'($urandom), 1'($urandom), 1'($urandom), $urandom % 4);
            run();
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule